// File: doc/BRIEF.md
# Sample-Memory Write Pointer with Trigger Reservation

This block drives the write address of a 192-cell circular sample store that takes one sample per clock. When a trigger arrives, it locks the three cells that held the samples taken a programmable number of cycles earlier. It places their addresses in a readout queue. From then on, the write pointer jumps over every locked cell, so sampling never pauses and no held sample is overwritten. The readout side reads the queue head. It asserts a done strobe for each cell it has read, and that strobe releases one reservation on the cell.

The write pointer can jump over cells, so the physical cells that were in use some cycles ago cannot be found by subtracting from the current address. The block therefore keeps a log, indexed by time, of the address written on every cycle, and the trigger lookback reads from that log. Each cell has a reservation counter. Triggers that fall fewer than three cycles apart can share cells, and a shared cell becomes writable again only after its last reservation is released.

A small state machine has two states: WARM and RUN. Reset enters WARM. While in WARM the log is still shorter than the longest lookback, and triggers are ignored. The transition WARM→RUN, named *history_full*, fires after 181 cycles. RUN is held until the next reset.

Top module: `skip_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, wr_addr is 0, rd_valid is 0, and ovf_flag and err_flag are 0.
- R2: When no cell is reserved, wr_addr increases by one on every clock and wraps from 191 to 0. After 192 clocks from reset with no accepted trigger, wr_addr is back at 0.
- R3: On each clock, wr_addr moves to the first cell after the current one, in circular order, that has no reservation and is not being reserved on that clock. It passes over any run of reserved cells (45 or more) in that single clock, and wr_addr never names a reserved cell.
- R4: A trigger accepted on a clock where the effective latency is L reserves the cells that wr_addr showed L+1, L and L−1 clocks earlier. It appends them to the queue in that order, oldest first.
- R5: The effective latency is lat_cfg clamped to the range 3 to 180. Values 0–2 act as 3, and values 181–255 act as 180.
- R6: rd_valid is 1 exactly when the queue is non-empty, and rd_addr shows the oldest queued cell. A rd_done while rd_valid is high removes that entry. Entries leave in trigger order and, within a trigger, in sample order. The queue holds 48 entries.
- R7: Each cell keeps a count of its reservations. Every accepted trigger adds one for each time the cell appears in its three entries, and every pop subtracts one. A cell can be written again only when its count is zero, so triggers one or two clocks apart share cells.
- R8: A trigger that arrives in RUN while more than 45 entries are queued (16 triggers pending) is dropped. It sets ovf_flag, which stays at 1 until reset.
- R9: A rd_done while the queue is empty sets err_flag, which stays at 1 until reset. It changes neither the queue nor any reservation.
- R10: Triggers in the first 181 clocks after reset (state WARM) are ignored. They reserve nothing, queue nothing and do not set ovf_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 1 | Trigger, sampled on each rising edge |
| lat_cfg | input | 8 | Trigger latency in clocks, before clamping |
| rd_done | input | 1 | Pop strobe for the queue head |
| wr_addr | output | 8 | Cell written on this clock |
| rd_valid | output | 1 | Queue is non-empty |
| rd_addr | output | 8 | Oldest queued cell |
| ovf_flag | output | 1 | Sticky: a trigger was dropped |
| err_flag | output | 1 | Sticky: pop on an empty queue |

## Verification
The bench goes after a burst of fifteen triggers three clocks apart, which leaves a 45-cell locked run. A pointer that advanced one cell per clock would write into that run, and a pointer that stalled would repeat an address. Triggers one clock apart test cell sharing: a single reservation bit per cell would free a shared cell at its first pop, and the pointer would then overwrite it too early. The bench also drives latency values outside the range, where missing clamping would read the log across its wrap point. It tests the exact 46-entry overflow threshold, pops on an empty queue (which must leave the reservations untouched), and triggers during warm-up, which a design without the WARM state would queue from an empty log.

// File: rtl/skip_ctrl_pkg.sv
package skip_ctrl_pkg;

    typedef enum logic {
        ST_WARM = 1'b0,
        ST_RUN  = 1'b1
    } sc_state_e;

endpackage

// File: rtl/sc_resv_ptr.sv
module sc_resv_ptr #(
    parameter int NCELLS  = 192,
    parameter int SAMPLES = 3,
    parameter int QDEPTH  = 48,
    localparam int AW = $clog2(NCELLS),
    localparam int CW = $clog2(QDEPTH + 1),
    localparam int IW = $clog2(SAMPLES + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           add_en,
    input  logic [SAMPLES-1:0][AW-1:0]     add_cells,
    input  logic                           rel_en,
    input  logic [AW-1:0]                  rel_cell,
    output logic [AW-1:0]                  wr_addr
);

    logic [CW-1:0]     cnt_q   [NCELLS];
    logic [IW-1:0]     inc     [NCELLS];
    logic [NCELLS-1:0] dec;
    logic [NCELLS-1:0] held;
    logic [NCELLS-1:0] blocked;
    logic [AW-1:0]     wr_q;
    logic [AW-1:0]     nxt;
    logic [AW:0]       probe;

    // per-cell increment, decrement and occupancy view
    always_comb begin
        for (int j = 0; j < NCELLS; j++) begin
            inc[j] = '0;
            for (int s = 0; s < SAMPLES; s++) begin
                if (add_en && (add_cells[s] == AW'(j))) begin
                    inc[j] = inc[j] + IW'(1);
                end
            end
            dec[j]     = rel_en && (rel_cell == AW'(j));
            held[j]    = (cnt_q[j] != '0);
            blocked[j] = held[j] || (inc[j] != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < NCELLS; j++) begin
                cnt_q[j] <= '0;
            end
        end else begin
            for (int j = 0; j < NCELLS; j++) begin
                cnt_q[j] <= cnt_q[j] + CW'(inc[j]) - CW'(dec[j]);
            end
        end
    end

    // first free cell after the current one, circular; nearest wins
    always_comb begin
        nxt   = wr_q;
        probe = '0;
        for (int i = NCELLS - 1; i >= 1; i--) begin
            probe = {1'b0, wr_q} + (AW + 1)'(i);
            if (probe >= (AW + 1)'(NCELLS)) begin
                probe = probe - (AW + 1)'(NCELLS);
            end
            if (!blocked[probe[AW-1:0]]) begin
                nxt = probe[AW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= nxt;
        end
    end

    assign wr_addr = wr_q;

    // R2
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q < AW'(NCELLS));

    // R3
    no_write_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !held[wr_q]);

    // R7
    release_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |-> held[rel_cell]);

endmodule

// File: rtl/sc_hist_log.sv
module sc_hist_log #(
    parameter int HDEPTH  = 192,
    parameter int AW      = 8,
    parameter int LW      = 8,
    parameter int SAMPLES = 3,
    parameter int LMIN    = 3,
    parameter int LMAX    = 180,
    localparam int HALF   = (SAMPLES - 1) / 2,
    localparam int HPW    = $clog2(HDEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              cell_in,
    input  logic [LW-1:0]              lat,
    output logic [SAMPLES-1:0][AW-1:0] cells_out
);

    logic [AW-1:0]  log_q [HDEPTH];
    logic [HPW-1:0] head_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            for (int i = 0; i < HDEPTH; i++) begin
                log_q[i] <= '0;
            end
        end else begin
            log_q[head_q] <= cell_in;
            head_q        <= (head_q == HPW'(HDEPTH - 1)) ? '0 : head_q + HPW'(1);
        end
    end

    // sample s was written (lat + HALF - s) clocks ago
    always_comb begin
        for (int s = 0; s < SAMPLES; s++) begin
            int ago;
            int pos;
            ago = int'(lat) + HALF - s;
            pos = int'(head_q) - ago;
            if (pos < 0) begin
                pos = pos + HDEPTH;
            end
            cells_out[s] = log_q[pos[HPW-1:0]];
        end
    end

    // R5
    lat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lat) >= LMIN) && (int'(lat) <= LMAX) && (int'(lat) + HALF < HDEPTH));

endmodule

// File: rtl/sc_addr_fifo.sv
module sc_addr_fifo #(
    parameter int DEPTH   = 48,
    parameter int AW      = 8,
    parameter int SAMPLES = 3,
    localparam int PW     = $clog2(DEPTH),
    localparam int OW     = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_en,
    input  logic [SAMPLES-1:0][AW-1:0] push_cells,
    input  logic                       pop_req,
    output logic                       pop_ok,
    output logic                       valid,
    output logic [AW-1:0]              head,
    output logic [OW-1:0]              occ
);

    logic [AW-1:0] mem_q [DEPTH];
    logic [PW-1:0] rptr_q;
    logic [PW-1:0] wptr_q;
    logic [OW-1:0] occ_q;

    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int n);
        int t;
        t = int'(p) + n;
        if (t >= DEPTH) begin
            t = t - DEPTH;
        end
        return t[PW-1:0];
    endfunction

    assign valid  = (occ_q != '0);
    assign pop_ok = pop_req && valid;
    assign head   = mem_q[rptr_q];
    assign occ    = occ_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q <= '0;
            wptr_q <= '0;
            occ_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (push_en) begin
                for (int s = 0; s < SAMPLES; s++) begin
                    mem_q[wrap_add(wptr_q, s)] <= push_cells[s];
                end
                wptr_q <= wrap_add(wptr_q, SAMPLES);
            end
            if (pop_ok) begin
                rptr_q <= wrap_add(rptr_q, 1);
            end
            occ_q <= occ_q + (push_en ? OW'(SAMPLES) : '0) - (pop_ok ? OW'(1) : '0);
        end
    end

    // R6
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OW'(DEPTH));

    // R9
    empty_pop_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !valid && !push_en) |=> (occ_q == '0));

endmodule

// File: rtl/skip_ctrl.sv
module skip_ctrl #(
    parameter int NCELLS  = 192,
    parameter int SAMPLES = 3,
    parameter int MAXTRIG = 16,
    parameter int LATW    = 8,
    parameter int LMIN    = 3,
    parameter int LMAX    = 180,
    localparam int AW     = $clog2(NCELLS),
    localparam int QDEPTH = SAMPLES * MAXTRIG,
    localparam int OW     = $clog2(QDEPTH + 1),
    localparam int HALF   = (SAMPLES - 1) / 2,
    localparam int WARM   = LMAX + HALF,
    localparam int WCW    = $clog2(WARM + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_in,
    input  logic [LATW-1:0] lat_cfg,
    input  logic            rd_done,
    output logic [AW-1:0]   wr_addr,
    output logic            rd_valid,
    output logic [AW-1:0]   rd_addr,
    output logic            ovf_flag,
    output logic            err_flag
);
    import skip_ctrl_pkg::*;

    sc_state_e             state_q, state_d;
    logic [WCW-1:0]        warm_q, warm_d;
    logic                  run;
    logic [LATW-1:0]       lat_eff;
    logic [SAMPLES-1:0][AW-1:0] look_cells;
    logic                  trig_ok;
    logic                  trig_drop;
    logic                  pop_ok;
    logic [OW-1:0]         occ;
    logic                  ovf_q, err_q;

    // latency clamp
    always_comb begin
        if (int'(lat_cfg) < LMIN) begin
            lat_eff = LATW'(LMIN);
        end else if (int'(lat_cfg) > LMAX) begin
            lat_eff = LATW'(LMAX);
        end else begin
            lat_eff = lat_cfg;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WARM;
            warm_q  <= '0;
        end else begin
            state_q <= state_d;
            warm_q  <= warm_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        warm_d  = warm_q;
        run     = 1'b0;
        unique case (state_q)
            ST_WARM: begin
                warm_d = warm_q + WCW'(1);
                if (warm_q == WCW'(WARM - 1)) begin
                    state_d = ST_RUN;   // history_full
                end
            end
            ST_RUN: begin
                run = 1'b1;
            end
            default: begin
                state_d = ST_WARM;
            end
        endcase
    end

    assign trig_ok   = run && trig_in && (occ <= OW'(QDEPTH - SAMPLES));
    assign trig_drop = run && trig_in && !trig_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (trig_drop) begin
                ovf_q <= 1'b1;
            end
            if (rd_done && !rd_valid) begin
                err_q <= 1'b1;
            end
        end
    end

    assign ovf_flag = ovf_q;
    assign err_flag = err_q;

    sc_hist_log #(
        .HDEPTH (NCELLS),
        .AW     (AW),
        .LW     (LATW),
        .SAMPLES(SAMPLES),
        .LMIN   (LMIN),
        .LMAX   (LMAX)
    ) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_in  (wr_addr),
        .lat      (lat_eff),
        .cells_out(look_cells)
    );

    sc_addr_fifo #(
        .DEPTH  (QDEPTH),
        .AW     (AW),
        .SAMPLES(SAMPLES)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (trig_ok),
        .push_cells(look_cells),
        .pop_req   (rd_done),
        .pop_ok    (pop_ok),
        .valid     (rd_valid),
        .head      (rd_addr),
        .occ       (occ)
    );

    sc_resv_ptr #(
        .NCELLS (NCELLS),
        .SAMPLES(SAMPLES),
        .QDEPTH (QDEPTH)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (trig_ok),
        .add_cells(look_cells),
        .rel_en   (pop_ok),
        .rel_cell (rd_addr),
        .wr_addr  (wr_addr)
    );

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R10
    warm_no_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM) |=> (occ == '0) && !ovf_q);

    // R8
    full_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ > OW'(QDEPTH - SAMPLES) && !rd_done) |=> (occ <= $past(occ)));

endmodule

// File: tb/skip_ctrl_tb.sv
module skip_ctrl_tb;

    localparam int NC   = 192;
    localparam int QD   = 48;
    localparam int WARM = 181;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_in = 1'b0;
    logic [7:0] lat_cfg = 8'd10;
    logic       rd_done = 1'b0;
    logic [7:0] wr_addr;
    logic       rd_valid;
    logic [7:0] rd_addr;
    logic       ovf_flag;
    logic       err_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    string tag = "R1";

    // reference model state
    int m_wr, m_cyc, m_head;
    int m_log [NC];
    int m_cnt [NC];
    int m_q [$];
    bit m_ovf, m_err;

    always #4 clk = ~clk;

    skip_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .lat_cfg (lat_cfg),
        .rd_done (rd_done),
        .wr_addr (wr_addr),
        .rd_valid(rd_valid),
        .rd_addr (rd_addr),
        .ovf_flag(ovf_flag),
        .err_flag(err_flag)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int clamp_lat(input int l);
        if (l < 3) return 3;
        if (l > 180) return 180;
        return l;
    endfunction

    task automatic model_reset();
        m_wr = 0; m_cyc = 0; m_head = 0;
        m_ovf = 0; m_err = 0;
        m_q.delete();
        for (int j = 0; j < NC; j++) begin
            m_log[j] = 0;
            m_cnt[j] = 0;
        end
    endtask

    task automatic model_step(input bit t, input int lat, input bit d);
        int L;
        int c [3];
        bit blk [NC];
        bit acc;
        int nx;
        L = clamp_lat(lat);
        acc = 0;
        if (m_cyc >= WARM && t) begin
            if (m_q.size() <= QD - 3) acc = 1;
            else m_ovf = 1;
        end
        for (int s = 0; s < 3; s++) begin
            c[s] = m_log[(m_head - (L + 1 - s) + 2 * NC) % NC];
        end
        for (int j = 0; j < NC; j++) blk[j] = (m_cnt[j] != 0);
        if (acc) for (int s = 0; s < 3; s++) blk[c[s]] = 1;
        nx = m_wr;
        for (int i = 1; i < NC; i++) begin
            if (!blk[(m_wr + i) % NC]) begin
                nx = (m_wr + i) % NC;
                break;
            end
        end
        if (d) begin
            if (m_q.size() > 0) begin
                int x;
                x = m_q.pop_front();
                m_cnt[x]--;
            end else begin
                m_err = 1;
            end
        end
        if (acc) begin
            for (int s = 0; s < 3; s++) begin
                m_q.push_back(c[s]);
                m_cnt[c[s]]++;
            end
        end
        m_log[m_head] = m_wr;
        m_head = (m_head + 1) % NC;
        m_wr = nx;
        m_cyc++;
    endtask

    task automatic compare_all();
        chk("R2/R3 wr_addr", int'(wr_addr), m_wr);
        chk("R6 rd_valid", int'(rd_valid), int'(m_q.size() > 0));
        if (m_q.size() > 0) chk("R4/R6 rd_addr", int'(rd_addr), m_q[0]);
        chk("R8 ovf_flag", int'(ovf_flag), int'(m_ovf));
        chk("R9 err_flag", int'(err_flag), int'(m_err));
    endtask

    // called at a falling edge: drive, predict, advance, compare
    task automatic step(input bit t, input int lat, input bit d);
        trig_in = t;
        lat_cfg = 8'(lat);
        rd_done = d;
        model_step(t, lat, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        trig_in = 1'b0;
        rd_done = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rand_run(input int n, input int tp, input int pp);
        for (int k = 0; k < n; k++) begin
            int l;
            l = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 255) : $urandom_range(3, 180);
            step($urandom_range(0, 99) < tp, l, $urandom_range(0, 99) < pp);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));

        // R1: reset state
        tag = "R1";
        do_reset();
        chk("R1 wr_addr", int'(wr_addr), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 ovf_flag", int'(ovf_flag), 0);
        chk("R1 err_flag", int'(err_flag), 0);

        // R10: triggers during warm-up are ignored
        tag = "R10";
        for (int k = 0; k < WARM; k++) step(k % 2 == 0, 10, 1'b0);
        chk("R10 rd_valid after warm", int'(rd_valid), 0);
        chk("R10 ovf after warm", int'(ovf_flag), 0);

        // R2: plain wrap back to cell 0 after 192 clocks
        tag = "R2";
        for (int k = WARM; k < NC; k++) step(1'b0, 10, 1'b0);
        chk("R2 wrap to 0", int'(wr_addr), 0);

        // R3/R4: 15 triggers 3 apart lock a 45-cell run, pointer must skip it
        tag = "R3";
        for (int k = 0; k < 45; k++) step(k % 3 == 0, 10, 1'b0);
        chk("R4 queue depth 45", int'(rd_valid), 1);
        for (int k = 0; k < 200; k++) step(1'b0, 10, 1'b0);

        // R8: 16th trigger accepted, 17th dropped
        tag = "R8";
        step(1'b1, 10, 1'b0);
        chk("R8 no ovf at 16", int'(ovf_flag), 0);
        step(1'b1, 10, 1'b0);
        chk("R8 ovf at 17", int'(ovf_flag), 1);

        // R6/R9: drain then pop on empty
        tag = "R9";
        for (int k = 0; k < 52; k++) step(1'b0, 10, 1'b1);
        chk("R9 err after empty pops", int'(err_flag), 1);
        chk("R9 queue stays empty", int'(rd_valid), 0);
        for (int k = 0; k < 200; k++) step(1'b0, 10, 1'b0);

        // R5 and R7: clamped latencies and back-to-back shared cells
        do_reset();
        tag = "R10";
        for (int k = 0; k < WARM; k++) step(1'b0, 0, 1'b0);
        tag = "R5";
        step(1'b1, 0, 1'b0);
        step(1'b1, 255, 1'b0);
        step(1'b1, 2, 1'b0);
        step(1'b1, 181, 1'b0);
        tag = "R7";
        for (int k = 0; k < 6; k++) step(1'b1, 20, 1'b0);
        for (int k = 0; k < 400; k++) step(1'b0, 20, k % 4 == 0);

        // random mix
        tag = "R6";
        rand_run(3000, 12, 40);
        do_reset();
        tag = "R8";
        rand_run(3000, 25, 20);
        tag = "R7";
        rand_run(2000, 30, 60);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule